// File: doc/BRIEF.md
# Memory Test Command Sequencer

This block replays a short, programmed list of DRAM commands for memory training and test. It has four command slots. Each slot holds the levels of the three command strobes, per-rank clock-enable, termination and chip-select values, and a timing word. The timing word gives how many times the slot's command repeats, how many quiet clocks follow each issue, how many quiet clocks close the slot, and the data direction reported alongside the command. A control word selects the last slot to run, sets a number of full passes over the slots, and sets a pause after each pass during which maintenance work may run.

Writing a non-zero pass count starts the engine at once. The count drops by one after each pass and the engine stops with DONE when it reaches zero. The all-ones count loops forever until software writes zero. A pulse from an external data checker can halt the run when stop-on-error is set, and it can raise a sticky trigger output. A refresh-panic input aborts any run. Every clock that carries no command is a deselect clock.

Top module: `memseq_engine`

## Requirements
- R1: After reset the engine is idle (IDLE high; BUSY, DONE, ERROR, PANIC and the trigger low), no command is valid, the chip selects and the three strobes are all high, and CKE and ODT are zero.
- R2: Writes use a 4-bit address. Addresses 0 to 3 hold the command word of slots 0 to 3: bit 0 RAS_n, bit 1 CAS_n, bit 2 WE_n, bits 7:4 CKE, bits 11:8 ODT, bits 15:12 active-low chip selects. Addresses 4 to 7 hold the timing word of slots 0 to 3: bits 8:0 repeat count, bits 13:9 gap, bits 22:14 slot idle, bits 25:24 direction. Address 8 is the control word: bits 7:0 pass count, bits 16:8 pass wait, bit 17 stop-on-error, bits 19:18 last slot index, bit 20 trigger enable. Writes to addresses 9 to 15 have no effect.
- R3: A control write with a non-zero pass count presents slot 0's first command in the next clock with BUSY high, and it clears DONE, ERROR, PANIC and the trigger. This holds even while a run is in progress, which then restarts from slot 0.
- R4: A slot issues its command on a number of clocks equal to its repeat count, with a count of zero treated as one. Each command lasts one clock and is followed by gap deselect clocks.
- R5: After the last repetition's gap, a slot adds its idle count of deselect clocks. Slots then run in order from 0 to the last slot index, so an index of 0 runs one slot and 3 runs four.
- R6: After each full pass, a non-zero pass wait adds that many deselect clocks with the maintenance output high. The maintenance output is low at all other times.
- R7: Passes repeat until the pass count is used up. In the clock after the final pass the engine shows IDLE and DONE.
- R8: A pass count of 255 never decrements, so the run loops forever. A control write with a zero count aborts a run, and the engine returns to IDLE without setting DONE.
- R9: With stop-on-error set, an error pulse during a run halts the engine in the next clock with ERROR set. Without it, the run continues unchanged. Error pulses while idle are ignored.
- R10: With trigger enable set, the first error pulse of a run raises the trigger output. It stays high until the next start, whether or not the run stops.
- R11: A panic pulse during a run aborts it in the next clock with PANIC set. Panic wins over a simultaneous error. Panic while idle is ignored.
- R12: A command clock presents the slot index and the slot's direction (00 none, 01 read, 10 write, 11 both) with the valid flag. Between commands, CKE and ODT hold the values of the last issued command.
- R13: On every clock that carries no command, all chip selects and RAS_n, CAS_n and WE_n are high, the direction is 00 and the valid flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| err_in | input | 1 | Error pulse from the data checker |
| panic_in | input | 1 | Refresh panic request |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable strobe, active low |
| cs_n | output | 4 | Per-rank chip selects, active low |
| cke | output | 4 | Per-rank clock enable |
| odt | output | 4 | Per-rank on-die termination |
| cmd_valid | output | 1 | A slot command is issued this clock |
| cmd_slot | output | 2 | Slot index of the issued command |
| cmd_dir | output | 2 | Data direction of the issued command |
| maint_ok | output | 1 | Pass wait in progress, maintenance allowed |
| trig_out | output | 1 | Sticky first-error trigger |
| st_idle | output | 1 | Status: idle |
| st_busy | output | 1 | Status: running |
| st_done | output | 1 | Status: last run completed |
| st_error | output | 1 | Status: stopped on error |
| st_panic | output | 1 | Status: aborted by panic |

## Verification
Some properties are checked on every clock: IDLE and BUSY are exclusive, deselect clocks are quiet, commands and the maintenance window appear only during a run, DONE implies idle, a panic during a run aborts it, the trigger holds, and ERROR rises only after an error pulse. The exact clock-by-clock order of commands, gaps, slot idles and pass waits needs the bench's reference trace. So do the repeat-count rule for zero, the 255 loop, abort by a zero write, the clearing of flags on restart, and the CKE and ODT hold. These are compared against the trace under several slot programs.

// File: rtl/memseq_engine.sv
module memseq_engine #(
  parameter int REP_W  = 9,
  parameter int GAP_W  = 5,
  parameter int IDLE_W = 9,
  parameter int WAIT_W = 9,
  parameter int ITER_W = 8,
  parameter int RANK_N = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              err_in,
  input  logic              panic_in,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [RANK_N-1:0] cs_n,
  output logic [RANK_N-1:0] cke,
  output logic [RANK_N-1:0] odt,
  output logic              cmd_valid,
  output logic [1:0]        cmd_slot,
  output logic [1:0]        cmd_dir,
  output logic              maint_ok,
  output logic              trig_out,
  output logic              st_idle,
  output logic              st_busy,
  output logic              st_done,
  output logic              st_error,
  output logic              st_panic
);
  localparam int CKE_LSB  = 4;
  localparam int ODT_LSB  = CKE_LSB + RANK_N;
  localparam int CS_LSB   = ODT_LSB + RANK_N;
  localparam int CMDW_W   = CS_LSB + RANK_N;
  localparam int GAP_LSB  = REP_W;
  localparam int IDL_LSB  = GAP_LSB + GAP_W;
  localparam int DIR_LSB  = IDL_LSB + IDLE_W + 1;
  localparam int TIM_W    = DIR_LSB + 2;
  localparam int WAIT_LSB = ITER_W;
  localparam int STOP_BIT = WAIT_LSB + WAIT_W;
  localparam int LAST_LSB = STOP_BIT + 1;
  localparam int TRIG_BIT = LAST_LSB + 2;
  localparam int CNT_A    = (GAP_W > IDLE_W) ? GAP_W : IDLE_W;
  localparam int CNT_W    = (CNT_A > WAIT_W) ? CNT_A : WAIT_W;
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(8);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_GAP, S_SUB, S_WAIT} st_t;

  st_t state, n_state;
  logic [CMDW_W-1:0] cmd_q [4];
  logic [TIM_W-1:0]  tim_q [4];
  logic [WAIT_W-1:0] wait_q;
  logic              stop_q, trig_en_q;
  logic [1:0]        last_q;
  logic [1:0]        slot, n_slot;
  logic [REP_W-1:0]  rep_left, n_rep;
  logic [CNT_W-1:0]  cnt, n_cnt;
  logic [ITER_W-1:0] iter, n_iter;
  logic              step_rep, end_slot, end_pass, fin;
  logic              done_q, err_q, panic_q, trig_q;
  logic [RANK_N-1:0] cke_hold, odt_hold;

  wire ctl_wr  = wr_en && (wr_addr == CTL_ADDR);
  wire cmd_wr  = wr_en && (wr_addr[ADDR_W-1:2] == '0);
  wire tim_wr  = wr_en && (wr_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));
  wire issuing = (state == S_CMD);
  wire running = (state != S_IDLE);

  wire [CMDW_W-1:0] cur_cmd  = cmd_q[slot];
  wire [TIM_W-1:0]  cur_tim  = tim_q[slot];
  wire [GAP_W-1:0]  gap_cur  = cur_tim[GAP_LSB +: GAP_W];
  wire [IDLE_W-1:0] idle_cur = cur_tim[IDL_LSB +: IDLE_W];

  function automatic logic [REP_W-1:0] eff_rep(input logic [TIM_W-1:0] t);
    logic [REP_W-1:0] r;
    r = t[REP_W-1:0];
    return (r == '0) ? REP_W'(1) : r;
  endfunction

  always_comb begin
    n_state  = state;
    n_slot   = slot;
    n_rep    = rep_left;
    n_cnt    = cnt;
    n_iter   = iter;
    fin      = 1'b0;
    step_rep = 1'b0;
    end_slot = 1'b0;
    end_pass = 1'b0;
    case (state)
      S_CMD:
        if (gap_cur != '0) begin
          n_state = S_GAP;
          n_cnt   = CNT_W'(gap_cur);
        end else step_rep = 1'b1;
      S_GAP:  if (cnt == CNT_W'(1)) step_rep = 1'b1; else n_cnt = cnt - CNT_W'(1);
      S_SUB:  if (cnt == CNT_W'(1)) end_slot = 1'b1; else n_cnt = cnt - CNT_W'(1);
      S_WAIT: if (cnt == CNT_W'(1)) end_pass = 1'b1; else n_cnt = cnt - CNT_W'(1);
      default: ;
    endcase
    if (step_rep) begin
      if (rep_left > REP_W'(1)) begin
        n_rep   = rep_left - REP_W'(1);
        n_state = S_CMD;
      end else if (idle_cur != '0) begin
        n_state = S_SUB;
        n_cnt   = CNT_W'(idle_cur);
      end else end_slot = 1'b1;
    end
    if (end_slot) begin
      if (slot != last_q) begin
        n_slot  = slot + 2'd1;
        n_rep   = eff_rep(tim_q[slot + 2'd1]);
        n_state = S_CMD;
      end else if (wait_q != '0) begin
        n_state = S_WAIT;
        n_cnt   = CNT_W'(wait_q);
      end else end_pass = 1'b1;
    end
    if (end_pass) begin
      if (iter == '1 || iter != ITER_W'(1)) begin
        if (iter != '1) n_iter = iter - ITER_W'(1);
        n_slot  = 2'd0;
        n_rep   = eff_rep(tim_q[0]);
        n_state = S_CMD;
      end else begin
        n_iter  = '0;
        n_state = S_IDLE;
        fin     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        cmd_q[i] <= '1;
        tim_q[i] <= '0;
      end
      wait_q    <= '0;
      stop_q    <= 1'b0;
      trig_en_q <= 1'b0;
      last_q    <= 2'd0;
    end else begin
      if (cmd_wr) cmd_q[wr_addr[1:0]] <= wr_data[CMDW_W-1:0];
      if (tim_wr) tim_q[wr_addr[1:0]] <= wr_data[TIM_W-1:0];
      if (ctl_wr) begin
        wait_q    <= wr_data[WAIT_LSB +: WAIT_W];
        stop_q    <= wr_data[STOP_BIT];
        last_q    <= wr_data[LAST_LSB +: 2];
        trig_en_q <= wr_data[TRIG_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      slot     <= 2'd0;
      rep_left <= '0;
      cnt      <= '0;
      iter     <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      panic_q  <= 1'b0;
      trig_q   <= 1'b0;
    end else if (ctl_wr) begin
      if (wr_data[ITER_W-1:0] != '0) begin
        state    <= S_CMD;
        slot     <= 2'd0;
        rep_left <= eff_rep(tim_q[0]);
        cnt      <= '0;
        iter     <= wr_data[ITER_W-1:0];
        done_q   <= 1'b0;
        err_q    <= 1'b0;
        panic_q  <= 1'b0;
        trig_q   <= 1'b0;
      end else begin
        state <= S_IDLE;
        iter  <= '0;
      end
    end else if (running) begin
      if (panic_in) begin
        state   <= S_IDLE;
        iter    <= '0;
        panic_q <= 1'b1;
      end else begin
        if (err_in && trig_en_q) trig_q <= 1'b1;
        if (err_in && stop_q) begin
          state <= S_IDLE;
          iter  <= '0;
          err_q <= 1'b1;
        end else begin
          state    <= n_state;
          slot     <= n_slot;
          rep_left <= n_rep;
          cnt      <= n_cnt;
          iter     <= n_iter;
          if (fin) done_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_hold <= '0;
      odt_hold <= '0;
    end else begin
      cke_hold <= cke;
      odt_hold <= odt;
    end
  end

  assign ras_n     = issuing ? cur_cmd[0] : 1'b1;
  assign cas_n     = issuing ? cur_cmd[1] : 1'b1;
  assign we_n      = issuing ? cur_cmd[2] : 1'b1;
  assign cs_n      = issuing ? cur_cmd[CS_LSB +: RANK_N]  : '1;
  assign cke       = issuing ? cur_cmd[CKE_LSB +: RANK_N] : cke_hold;
  assign odt       = issuing ? cur_cmd[ODT_LSB +: RANK_N] : odt_hold;
  assign cmd_valid = issuing;
  assign cmd_slot  = issuing ? slot : 2'd0;
  assign cmd_dir   = issuing ? cur_tim[DIR_LSB +: 2] : 2'b00;
  assign maint_ok  = (state == S_WAIT);
  assign trig_out  = trig_q;
  assign st_idle   = !running;
  assign st_busy   = running;
  assign st_done   = done_q;
  assign st_error  = err_q;
  assign st_panic  = panic_q;
endmodule

// File: rtl/memseq_engine_chk.sv
module memseq_engine_chk #(
  parameter int RANK_N = 4,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              err_in,
  input logic              panic_in,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [RANK_N-1:0] cs_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_dir,
  input logic              maint_ok,
  input logic              trig_out,
  input logic              st_idle,
  input logic              st_busy,
  input logic              st_done,
  input logic              st_error,
  input logic              st_panic
);
  wire ctl_wr = wr_en && (wr_addr == ADDR_W'(8));

  AST_IDLE_XOR_BUSY: assert property (@(posedge clk) disable iff (!rst_n) st_idle != st_busy); // R3
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (cs_n == '1 && ras_n && cas_n && we_n && cmd_dir == 2'b00)); // R13
  AST_CMD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |-> st_busy); // R3
  AST_MAINT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) maint_ok |-> (st_busy && !cmd_valid)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) st_done |-> st_idle); // R7
  AST_PANIC_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_busy && panic_in && !ctl_wr) |=> (st_idle && st_panic)); // R11
  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (trig_out && !ctl_wr) |=> trig_out); // R10
  AST_ERROR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(st_error) |-> $past(err_in)); // R9
endmodule

bind memseq_engine memseq_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .err_in(err_in),
  .panic_in(panic_in), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cs_n(cs_n),
  .cmd_valid(cmd_valid), .cmd_dir(cmd_dir), .maint_ok(maint_ok), .trig_out(trig_out),
  .st_idle(st_idle), .st_busy(st_busy), .st_done(st_done), .st_error(st_error),
  .st_panic(st_panic)
);

// File: tb/memseq_engine_tb.sv
module memseq_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic err_in = 1'b0;
  logic panic_in = 1'b0;
  logic ras_n, cas_n, we_n, cmd_valid, maint_ok, trig_out;
  logic st_idle, st_busy, st_done, st_error, st_panic;
  logic [3:0] cs_n, cke, odt;
  logic [1:0] cmd_slot, cmd_dir;

  always #4 clk = ~clk;

  memseq_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .err_in(err_in), .panic_in(panic_in), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cs_n(cs_n), .cke(cke), .odt(odt), .cmd_valid(cmd_valid), .cmd_slot(cmd_slot),
    .cmd_dir(cmd_dir), .maint_ok(maint_ok), .trig_out(trig_out), .st_idle(st_idle),
    .st_busy(st_busy), .st_done(st_done), .st_error(st_error), .st_panic(st_panic)
  );

  int tests = 0;
  int fails = 0;
  int q[$];
  bit m_done, m_err, m_pan, m_trig;
  logic [3:0] m_cke = '0, m_odt = '0;
  logic [15:0] b_cmd [4] = '{default: 16'hFFFF};
  logic [25:0] b_tim [4] = '{default: 26'd0};
  int b_wait = 0, b_last = 0;
  bit b_stop = 0, b_trig = 0;

  function automatic logic [31:0] cmdw(bit r, bit c, bit w, int ck, int od, int cs);
    return {16'd0, 4'(cs), 4'(od), 4'(ck), 1'b0, w, c, r};
  endfunction
  function automatic logic [31:0] timw(int reps, int gap, int idle, int dir);
    return {6'd0, 2'(dir), 1'b0, 9'(idle), 5'(gap), 9'(reps)};
  endfunction
  function automatic logic [31:0] ctlw(int iters, int wt, bit stop, int last, bit trig);
    return {11'd0, trig, 2'(last), stop, 9'(wt), 8'(iters)};
  endfunction

  function automatic void add_pass();
    for (int s = 0; s <= b_last; s++) begin
      int n = (b_tim[s][8:0] == 0) ? 1 : int'(b_tim[s][8:0]);
      for (int r = 0; r < n; r++) begin
        q.push_back(4 + s);
        for (int g = 0; g < int'(b_tim[s][13:9]); g++) q.push_back(0);
      end
      for (int i = 0; i < int'(b_tim[s][22:14]); i++) q.push_back(0);
    end
    for (int i = 0; i < b_wait; i++) q.push_back(8);
  endfunction

  task automatic check(input string tag);
    logic [26:0] act, exp;
    int ent, kind, s;
    logic [15:0] cw;
    ent = (q.size() > 0) ? q[0] : 0;
    kind = ent / 4;
    s = ent % 4;
    cw = b_cmd[s];
    act = {ras_n, cas_n, we_n, cs_n, cke, odt, cmd_valid, cmd_slot, cmd_dir, maint_ok,
           trig_out, st_idle, st_busy, st_done, st_error, st_panic};
    if (kind == 1)
      exp = {cw[0], cw[1], cw[2], cw[15:12], cw[7:4], cw[11:8], 1'b1, 2'(s), b_tim[s][25:24], 1'b0,
             m_trig, 1'b0, 1'b1, m_done, m_err, m_pan};
    else
      exp = {3'b111, 4'hF, m_cke, m_odt, 1'b0, 2'b00, 2'b00, kind == 2,
             m_trig, q.size() == 0, q.size() != 0, m_done, m_err, m_pan};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
    if (kind == 1) begin
      m_cke = cw[7:4];
      m_odt = cw[11:8];
    end
  endtask

  task automatic apply(input bit w, input logic [3:0] a, input logic [31:0] d,
                       input bit e, input bit p, input string tag);
    bit busy;
    wr_en = w; wr_addr = a; wr_data = d; err_in = e; panic_in = p;
    busy = q.size() > 0;
    @(posedge clk);
    #2;
    wr_en = 1'b0; err_in = 1'b0; panic_in = 1'b0;
    if (w && a[3:2] == 2'd0) b_cmd[a[1:0]] = d[15:0];
    if (w && a[3:2] == 2'd1) b_tim[a[1:0]] = d[25:0];
    if (w && a == 4'd8) begin
      b_wait = int'(d[16:8]); b_stop = d[17]; b_last = int'(d[19:18]); b_trig = d[20];
      q.delete();
      if (d[7:0] != 0) begin
        m_done = 0; m_err = 0; m_pan = 0; m_trig = 0;
        if (d[7:0] == 8'hFF) repeat (6) add_pass();
        else repeat (int'(d[7:0])) add_pass();
      end
    end else if (busy) begin
      if (p) begin
        q.delete(); m_pan = 1;
      end else begin
        if (e && b_trig) m_trig = 1;
        if (e && b_stop) begin
          q.delete(); m_err = 1;
        end else begin
          void'(q.pop_front());
          if (q.size() == 0) m_done = 1;
        end
      end
    end
    check(tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    apply(1, a, d, 0, 0, tag);
  endtask
  task automatic run(input int n, input string tag);
    repeat (n) apply(0, 4'd0, 32'd0, 0, 0, tag);
  endtask
  task automatic finish_run(input string tag);
    int guard = 0;
    while (q.size() > 0 && guard < 5000) begin
      apply(0, 4'd0, 32'd0, 0, 0, tag);
      guard++;
    end
    run(2, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1");
    rst_n = 1'b1;
    run(2, "R1");

    // R2 R4 R12: one slot, three repeats with gap 2, write direction
    wr(4'd0, cmdw(0, 1, 0, 4'hF, 4'h1, 4'hE), "R2");
    wr(4'd4, timw(3, 2, 0, 2), "R2");
    wr(4'd8, ctlw(1, 0, 0, 0, 0), "R3");
    finish_run("R4");

    // R5 R12: four slots, zero repeat count, zero gap, slot idles
    wr(4'd0, cmdw(0, 1, 1, 4'h1, 4'h8, 4'hE), "R2");
    wr(4'd1, cmdw(1, 0, 1, 4'h2, 4'h4, 4'hD), "R2");
    wr(4'd2, cmdw(1, 0, 0, 4'h4, 4'h2, 4'hB), "R2");
    wr(4'd3, cmdw(0, 0, 0, 4'h8, 4'h1, 4'h7), "R2");
    wr(4'd4, timw(2, 0, 3, 1), "R5");
    wr(4'd5, timw(0, 1, 0, 2), "R4");
    wr(4'd6, timw(1, 3, 2, 3), "R5");
    wr(4'd7, timw(2, 1, 1, 0), "R5");
    wr(4'd8, ctlw(1, 0, 0, 3, 0), "R5");
    finish_run("R5");
    run(3, "R12");

    // R6 R7: two passes over two slots with a pass wait
    wr(4'd8, ctlw(2, 3, 0, 1, 0), "R3");
    finish_run("R6");

    // R2: unmapped addresses are ignored
    wr(4'd9, 32'h0000_0001, "R2");
    wr(4'd12, 32'hFFFF_FFFF, "R2");
    wr(4'd15, 32'h0000_00FF, "R2");
    run(2, "R2");

    // R8: endless loop, then abort by zero count
    wr(4'd8, ctlw(255, 0, 0, 1, 0), "R3");
    run(40, "R8");
    wr(4'd8, ctlw(0, 0, 0, 1, 0), "R8");
    run(3, "R8");

    // R9 R10: stop on error with trigger
    wr(4'd8, ctlw(3, 0, 1, 3, 1), "R3");
    run(7, "R9");
    apply(0, 4'd0, 32'd0, 1, 0, "R9");
    run(3, "R10");
    apply(0, 4'd0, 32'd0, 1, 0, "R9");
    apply(0, 4'd0, 32'd0, 0, 1, "R11");
    run(2, "R9");

    // R3 R10: restart clears flags; error without stop keeps running
    wr(4'd8, ctlw(1, 2, 0, 2, 1), "R3");
    run(3, "R10");
    apply(0, 4'd0, 32'd0, 1, 0, "R10");
    run(2, "R10");
    apply(0, 4'd0, 32'd0, 1, 0, "R10");
    finish_run("R10");

    // R11: panic abort, panic wins over error
    wr(4'd8, ctlw(2, 0, 1, 2, 0), "R3");
    run(5, "R11");
    apply(0, 4'd0, 32'd0, 1, 1, "R11");
    run(3, "R11");

    // R3: restart in the middle of a run
    wr(4'd8, ctlw(2, 1, 0, 3, 0), "R3");
    run(6, "R3");
    wr(4'd8, ctlw(1, 0, 0, 0, 0), "R3");
    finish_run("R3");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule